// File: doc/BRIEF.md
# Variable-Length Byte Sequencer

This controller walks through the bytes of a wide data word one at a time. A start pulse captures a data word of eight bytes and a byte count. The controller then visits that many bytes, lowest byte first. Each byte goes through three processing phases, one clock cycle each. The byte being worked on and a strobe are shown on the outputs, so a downstream datapath can do its own per-byte work in each phase.

A parameterised idle gap separates consecutive bytes. After the last requested byte, the controller runs a fixed three-phase closing sequence, drops busy and pulses done for one cycle. A single index counter selects the byte and also tells the controller when to leave the per-byte loop. No state chain is hard-coded per byte. Requests for more bytes than the word holds are clamped, and a count of zero goes straight to the closing sequence.

Top module: `byte_sequencer`

## Requirements
- R1: While reset is asserted, and in every cycle after reset until a start is accepted, phase is 0, and busy, done, byte_strobe and cur_byte are all 0.
- R2: A start pulse seen in the idle state captures data_in and byte_count. When the captured count is non-zero, phase 1 for byte 0 appears in the next cycle.
- R3: Each byte goes through phase codes 1, 2 and 3 in that order, one cycle each. byte_strobe is high in exactly those cycles.
- R4: Bytes are visited in ascending order. During byte i's phases, cur_byte equals data bits [8i+7:8i]. cur_byte is 0 whenever byte_strobe is low.
- R5: Between the phase-3 cycle of one byte and the phase-1 cycle of the next, there are exactly GAP_CYCLES cycles with phase code 4, busy high and byte_strobe low. No gap follows the last byte.
- R6: The cycle after the last byte's phase 3 begins the closing sequence: phase codes 5, 6 and 7, one cycle each.
- R7: With a captured count of 0, the closing sequence begins in the cycle right after the start pulse, and no byte phase occurs.
- R8: A byte count above 8 is treated as 8.
- R9: done is high for exactly one cycle, the cycle after phase 7. In that cycle phase is 0 and busy is low. busy is high in every cycle from the first phase through phase 7.
- R10: A start pulse, or any change of data_in or byte_count, has no effect while busy is high. A start in the done cycle is accepted as a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a run; honoured only while idle |
| data_in | input | 64 | Eight-byte word, captured on an accepted start |
| byte_count | input | 4 | Number of bytes to visit, captured on an accepted start |
| cur_byte | output | 8 | Byte under processing while byte_strobe is high, else 0 |
| byte_strobe | output | 1 | High during each per-byte phase |
| phase | output | 3 | 0 idle, 1 to 3 byte phases, 4 gap, 5 to 7 closing phases |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the final closing phase |

## Verification
Every output comes straight from a register, so each result of a start sampled at edge k is due at edge k+1. From there the bench's expected trace advances exactly one entry per clock: three byte phases, then the gap cycles, then the closing phases, then a single done cycle. The bench model builds that trace from the captured word and the clamped count the moment it sees an accepted start. It then pops one entry at every falling edge and compares all outputs against it. Entries are never re-aligned, so a result that arrives one cycle early or late shows up as a mismatch. Starts are accepted only when the current expected entry shows busy low, which is how the model treats both mid-run pulses and restarts in the done cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_A    = 3'd1,
    S_B    = 3'd2,
    S_C    = 3'd3,
    S_GAP  = 3'd4,
    S_D    = 3'd5,
    S_E    = 3'd6,
    S_F    = 3'd7
  } seq_state_e;

endpackage

// File: rtl/seq_index_ctr.sv
module seq_index_ctr #(
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] total,
  output logic [IDX_W-1:0] idx,
  output logic             is_last
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  assign idx_en = clear | advance;

  always_comb begin
    idx_d = idx_q;
    if (clear)        idx_d = '0;
    else if (advance) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx     = idx_q;
  assign is_last = ((CNT_W'(idx_q) + 1'b1) == total);

  assert_idx_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx == '0));

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> (idx == $past(idx) + 1'b1));

  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(idx));

endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  generate
    if (GAP_CYCLES == 0) begin : g_nogap
      assign expired = 1'b1;
    end else begin : g_gap
      localparam int TW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
      localparam logic [TW-1:0] RELOAD = TW'(GAP_CYCLES - 1);

      logic [TW-1:0] tmr_q;
      logic [TW-1:0] tmr_d;
      logic          tmr_en;

      assign tmr_en = load | (tmr_q != '0);

      always_comb begin
        if (load) tmr_d = RELOAD;
        else      tmr_d = tmr_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tmr_q <= '0;
        else if (tmr_en) tmr_q <= tmr_d;
      end

      assign expired = (tmr_q == '0);

      assert_gap_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tmr_q != '0) |=> (tmr_q == $past(tmr_q) - 1'b1));

      assert_gap_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tmr_q == '0) |=> (tmr_q == '0));
    end
  endgenerate

endmodule

// File: rtl/seq_byte_sel.sv
module seq_byte_sel #(
  parameter int NUM_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_BYTES*BYTE_W-1:0] word_in,
  input  logic [IDX_W-1:0]            idx,
  output logic [BYTE_W-1:0]           byte_out
);

  logic [NUM_BYTES*BYTE_W-1:0] word_q;
  logic [BYTE_W-1:0]           lanes [NUM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign lanes[g] = word_q[g*BYTE_W +: BYTE_W];
  end

  assign byte_out = lanes[idx];

  assert_word_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_q));

endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_BYTES  = 8,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 4,
  parameter int GAP_CYCLES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_BYTES*BYTE_W-1:0] data_in,
  input  logic [CNT_W-1:0]            byte_count,
  output logic [BYTE_W-1:0]           cur_byte,
  output logic                        byte_strobe,
  output logic [2:0]                  phase,
  output logic                        busy,
  output logic                        done
);

  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_BYTES);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic             accept;
  logic             advance;
  logic             gap_load;
  logic             gap_expired;
  logic             is_last;
  logic [IDX_W-1:0] idx;
  logic [BYTE_W-1:0] sel_byte;
  logic             done_q;

  // Clamp the requested count to the word size (R8)
  assign cnt_eff = (byte_count > MAX_CNT) ? MAX_CNT : byte_count;
  assign accept  = start && (state_q == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (accept) cnt_q <= cnt_eff;
  end

  assign advance  = (state_q == S_C) && !is_last;
  assign gap_load = advance && (GAP_CYCLES != 0);

  seq_index_ctr #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .advance (advance),
    .total   (cnt_q),
    .idx     (idx),
    .is_last (is_last)
  );

  seq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .expired (gap_expired)
  );

  seq_byte_sel #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .word_in  (data_in),
    .idx      (idx),
    .byte_out (sel_byte)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = (cnt_eff == '0) ? S_D : S_A;
      S_A:    state_d = S_B;
      S_B:    state_d = S_C;
      S_C: begin
        if (is_last)              state_d = S_D;
        else if (GAP_CYCLES == 0) state_d = S_A;
        else                      state_d = S_GAP;
      end
      S_GAP:  if (gap_expired) state_d = S_A;
      S_D:    state_d = S_E;
      S_E:    state_d = S_F;
      S_F:    state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_F);
    end
  end

  assign phase       = state_q;
  assign busy        = (state_q != S_IDLE);
  assign byte_strobe = (state_q == S_A) || (state_q == S_B) || (state_q == S_C);
  assign cur_byte    = byte_strobe ? sel_byte : '0;
  assign done        = done_q;

  assert_a_to_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |=> (phase == 3'd2));

  assert_b_to_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |=> (phase == 3'd3));

  assert_last_to_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && is_last) |=> (phase == 3'd5));

  assert_more_bytes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && !is_last) |=> (phase == 3'd4 || phase == 3'd1));

  assert_close_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd5) |=> (phase == 3'd6));

  assert_close_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd6) |=> (phase == 3'd7));

  assert_done_after_f_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7) |=> (done && !busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_strobe_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_strobe |-> busy);

  assert_count_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cnt_q));

  assert_count_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= MAX_CNT));

endmodule

// File: tb/tb_byte_sequencer.sv
module tb_byte_sequencer;

  localparam int GAP = 2;

  typedef struct packed {
    logic       done;
    logic       busy;
    logic       strobe;
    logic [2:0] ph;
    logic [7:0] b;
    logic [3:0] tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [63:0] data_in;
  logic [3:0]  byte_count;
  logic [7:0]  cur_byte;
  logic        byte_strobe;
  logic [2:0]  phase;
  logic        busy;
  logic        done;

  int   compared;
  int   mismatched;
  bit   finished;
  exp_t q[$];

  byte_sequencer #(.GAP_CYCLES(GAP)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .data_in     (data_in),
    .byte_count  (byte_count),
    .cur_byte    (cur_byte),
    .byte_strobe (byte_strobe),
    .phase       (phase),
    .busy        (busy),
    .done        (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t mk(input logic d, input logic bz, input logic s,
                              input logic [2:0] p, input logic [7:0] b,
                              input logic [3:0] t);
    exp_t e;
    e.done = d; e.busy = bz; e.strobe = s; e.ph = p; e.b = b; e.tag = t;
    return e;
  endfunction

  // Behavioural expected trace of one run
  function automatic void push_run(input logic [63:0] d, input logic [3:0] c);
    int n;
    logic [3:0] tb_;
    n = (c > 4'd8) ? 8 : int'(c);
    for (int i = 0; i < n; i++) begin
      logic [7:0] by;
      by  = d[i*8 +: 8];
      tb_ = (i == 0) ? 4'd2 : ((c > 4'd8) ? 4'd8 : 4'd4);
      q.push_back(mk(1'b0, 1'b1, 1'b1, 3'd1, by, tb_));
      q.push_back(mk(1'b0, 1'b1, 1'b1, 3'd2, by, 4'd3));
      q.push_back(mk(1'b0, 1'b1, 1'b1, 3'd3, by, 4'd3));
      if (i < n - 1)
        for (int g = 0; g < GAP; g++)
          q.push_back(mk(1'b0, 1'b1, 1'b0, 3'd4, 8'h00, 4'd5));
    end
    tb_ = (n == 0) ? 4'd7 : 4'd6;
    q.push_back(mk(1'b0, 1'b1, 1'b0, 3'd5, 8'h00, tb_));
    q.push_back(mk(1'b0, 1'b1, 1'b0, 3'd6, 8'h00, 4'd6));
    q.push_back(mk(1'b0, 1'b1, 1'b0, 3'd7, 8'h00, 4'd6));
    q.push_back(mk(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9));
  endfunction

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else              e = mk(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, rst_n ? 4'd10 : 4'd1);
    if (!finished) begin
      compared++;
      if ({done, busy, byte_strobe, phase, cur_byte} !==
          {e.done, e.busy, e.strobe, e.ph, e.b}) begin
        mismatched++;
        $display("FAIL %s t=%0t: got done=%b busy=%b strobe=%b phase=%0d byte=%h, expected done=%b busy=%b strobe=%b phase=%0d byte=%h",
                 tag_name(e.tag), $time, done, busy, byte_strobe, phase, cur_byte,
                 e.done, e.busy, e.strobe, e.ph, e.b);
      end
      // R2 / R10: a start is taken only when the model is idle
      if (rst_n && !e.busy && start) push_run(data_in, byte_count);
    end
  end

  task automatic run(input logic [63:0] d, input logic [3:0] c, input int wait_n);
    @(posedge clk); #1;
    start = 1'b1; data_in = d; byte_count = c;
    @(posedge clk); #1;
    start = 1'b0; data_in = ~d; byte_count = 4'd5;  // R10: late input changes
    repeat (wait_n) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: got no completion, expected end of test");
      summary();
      $finish;
    end
  end

  initial begin
    compared = 0; mismatched = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; data_in = '0; byte_count = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;                                   // R1 checked while idle
    repeat (3) @(posedge clk);

    run(64'h8877_6655_4433_2211, 4'd3, 40);            // R2 R3 R4 R5 R6 R9
    run(64'hF0E1_D2C3_B4A5_9687, 4'd8, 50);            // full word, R4 R5
    run(64'hDEAD_BEEF_0BAD_F00D, 4'd0, 10);            // R7
    run(64'h0102_0304_0506_0708, 4'd12, 50);           // R8 clamp
    run(64'h1111_2222_3333_44AA, 4'd1, 10);            // single byte, no gap

    // R10: start pulse with new inputs in the middle of a run
    @(posedge clk); #1;
    start = 1'b1; data_in = 64'hCAFE_BABE_1234_5678; byte_count = 4'd4;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (5) @(posedge clk); #1;
    start = 1'b1; data_in = 64'h0; byte_count = 4'd8;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (30) @(posedge clk);

    // R10: start held high, restart taken in the done cycle
    @(posedge clk); #1;
    start = 1'b1; data_in = 64'h0000_0000_0000_00C3; byte_count = 4'd1;
    repeat (20) @(posedge clk); #1;
    start = 1'b0;
    repeat (20) @(posedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule